// File: doc/BRIEF.md
# Relaxation Iteration and Termination Controller

This block sequences a pipelined array of vertex-relaxation modules that computes single-source shortest paths on a weighted directed graph. Software loads edge words into a local edge memory and writes the number of valid edges. After a start pulse, the block runs a series of iterations. Each iteration begins with a one-cycle flag-clear pulse to the array. The block then streams every stored edge word once, one word per cycle, and waits for the pipeline to drain. At the end of the drain it samples the change flag that the array returns.

When an iteration leaves every label unchanged, the run ends early and the labels in the array are final. When labels are still changing after as many iterations as the array has vertices, the run ends and the block reports that a negative-weight cycle is reachable from the source. The block holds the result and the number of completed iterations until the next run is started. Each edge word is passed through unchanged. The array decodes it as `{dst index, src index, weight}`, with the weight in the low bits.

Top module: `relax_iter_ctrl`

## Requirements
- R1: After reset, `edgeValid`, `flagReset`, `done` and `noSolution` are 0, `busy` is 0 and `iterCount` is 0.
- R2: In each iteration the block drives `edgeValid` high for exactly E consecutive cycles, where E is the loaded edge count. In those cycles `edgeWord` equals the stored words at addresses 0, 1, … E-1, in that order.
- R3: `flagReset` is a single-cycle pulse in the cycle just before the first edge word of each iteration. It is never high at the same time as `edgeValid`.
- R4: After the last edge word, the block waits 2·N_VERT drain cycles and samples `stopIn` in the final drain cycle. One iteration therefore lasts exactly 1 + E + 2·N_VERT cycles.
- R5: If the sampled `stopIn` is 0, the run ends with `done`=1 and `noSolution`=0. `iterCount` then equals the number of iterations run, which is the final one included.
- R6: If the sampled `stopIn` is 1 at the end of iteration N_VERT, the run ends with `done`=1, `noSolution`=1 and `iterCount`=N_VERT.
- R7: `done`, `noSolution` and `iterCount` hold their values until the next accepted start. An accepted start clears `done` and `noSolution` one cycle later.
- R8: A `start` pulse while a run is active (`busy`=1) has no effect on the word stream, the iteration count or the result.
- R9: Edge-memory writes and edge-count writes while `busy`=1 are ignored.
- R10: With an edge count of 0, each iteration is a flag-clear cycle followed by the drain only, which is 1 + 2·N_VERT cycles with no valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| wrEn | input | 1 | Edge-memory write strobe |
| wrAddr | input | ADDR_W | Edge-memory write address |
| wrData | input | WORD_W | Edge word `{dst, src, weight}` |
| cntWr | input | 1 | Edge-count write strobe |
| cntIn | input | CNT_W | Number of valid edges, clamped to MEM_DEPTH |
| stopIn | input | 1 | Change flag returned by the array (1 = some label changed) |
| edgeValid | output | 1 | `edgeWord` carries a valid edge |
| edgeWord | output | WORD_W | Edge word streamed to the array |
| flagReset | output | 1 | Clears the array's update flags and its Stop register |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished |
| noSolution | output | 1 | Negative-weight cycle reachable |
| iterCount | output | ITER_W | Completed iterations of the current or last run |

## Verification
The bench builds the block with N_VERT=4, 8-bit weights and a 16-word memory. With these values the iteration limit is reached after four iterations, so both the early-exit path and the negative-cycle path are exercised many times. The bench also covers edge counts from 0 up to the full memory depth, and every drain window is short enough to check cycle by cycle. A scripted change flag stays high for a chosen number of iterations. From that number, the bench predicts the number of iterations, the total cycle count, every streamed word and the result.

// File: rtl/relax_iter_pkg.sv
package relax_iter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_FEED  = 2'd2,
    ST_DRAIN = 2'd3
  } ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;    // new run: clear iteration counter
    logic clrIter;   // new iteration: clear address and drain counters
    logic incAddr;   // advance read address
    logic incDrain;  // advance drain counter
    logic incIter;   // count a completed iteration
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeZero;
    logic lastWord;
    logic drainDone;
    logic atLimit;
  } dp_status_t;

endpackage

// File: rtl/relax_iter_dp.sv
module relax_iter_dp
  import relax_iter_pkg::*;
#(
  parameter int N_VERT    = 16,
  parameter int W_BITS    = 16,
  parameter int MEM_DEPTH = 64,
  localparam int IDX_W    = (N_VERT > 1) ? $clog2(N_VERT) : 1,
  localparam int WORD_W   = W_BITS + 2 * IDX_W,
  localparam int ADDR_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int CNT_W    = $clog2(MEM_DEPTH + 1),
  localparam int ITER_W   = $clog2(N_VERT + 1),
  localparam int DRAIN_LEN = 2 * N_VERT,
  localparam int DRAIN_W  = $clog2(DRAIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntIn,
  input  ctrl_strobe_t      strobe,
  input  logic              feeding,
  output dp_status_t        status,
  output logic [WORD_W-1:0] edgeWord,
  output logic [ITER_W-1:0] iterCount
);

  logic [WORD_W-1:0]  mem [MEM_DEPTH];
  logic [CNT_W-1:0]   edgeCnt;
  logic [ADDR_W-1:0]  rdAddr;
  logic [DRAIN_W-1:0] drainCnt;

  // edge memory, writable only while idle
  always_ff @(posedge clk) begin
    if (wrEn && !busy) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (cntWr && !busy) begin
      if (cntIn > CNT_W'(MEM_DEPTH)) edgeCnt <= CNT_W'(MEM_DEPTH);
      else                           edgeCnt <= cntIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr   <= '0;
      drainCnt <= '0;
    end else if (strobe.clrIter) begin
      rdAddr   <= '0;
      drainCnt <= '0;
    end else begin
      if (strobe.incAddr)  rdAddr   <= rdAddr + 1'b1;
      if (strobe.incDrain) drainCnt <= drainCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               iterCount <= '0;
    else if (strobe.clrRun)  iterCount <= '0;
    else if (strobe.incIter) iterCount <= iterCount + 1'b1;
  end

  always_comb begin
    status.edgeZero  = (edgeCnt == '0);
    status.lastWord  = ((CNT_W'(rdAddr) + CNT_W'(1)) == edgeCnt);
    status.drainDone = (drainCnt == DRAIN_W'(DRAIN_LEN - 1));
    status.atLimit   = (iterCount == ITER_W'(N_VERT - 1));
  end

  assign edgeWord = feeding ? mem[rdAddr] : '0;

  // R6: iterations never exceed the vertex count
  a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= ITER_W'(N_VERT));

  // R4: drain counter stays inside its window
  a_r4_drain_bound: assert property (@(posedge clk) disable iff (!rstN)
    drainCnt <= DRAIN_W'(DRAIN_LEN));

endmodule

// File: rtl/relax_iter_fsm.sv
module relax_iter_fsm
  import relax_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         stopIn,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         edgeValid,
  output logic         flagReset,
  output logic         busy,
  output logic         done,
  output logic         noSolution
);

  ctrl_state_t state, stateNxt;
  logic        decide;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    decide   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clrRun = 1'b1;
          stateNxt      = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        strobe.clrIter = 1'b1;
        stateNxt       = status.edgeZero ? ST_DRAIN : ST_FEED;
      end
      ST_FEED: begin
        strobe.incAddr = 1'b1;
        if (status.lastWord) stateNxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        strobe.incDrain = 1'b1;
        if (status.drainDone) begin
          strobe.incIter = 1'b1;
          decide         = 1'b1;
          if (!stopIn || status.atLimit) stateNxt = ST_IDLE;
          else                           stateNxt = ST_CLEAR;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      noSolution <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && start) begin
        done       <= 1'b0;
        noSolution <= 1'b0;
      end else if (decide && (!stopIn || status.atLimit)) begin
        done       <= 1'b1;
        noSolution <= stopIn;
      end
    end
  end

  assign edgeValid = (state == ST_FEED);
  assign flagReset = (state == ST_CLEAR);
  assign busy      = (state != ST_IDLE);

  // R3: flag clear is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flagReset |=> !flagReset);

  // R3: flag clear and valid words never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(flagReset && edgeValid));

  // R2: the word stream is unbroken until the last word
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (edgeValid && !status.lastWord) |=> edgeValid);

  // R4: the last word is followed by the drain, not a new word or clear
  a_r4_drain_follows: assert property (@(posedge clk) disable iff (!rstN)
    (edgeValid && status.lastWord) |=> (!edgeValid && !flagReset));

  // R6: a negative-cycle report only comes with done
  a_r6_nosol_done: assert property (@(posedge clk) disable iff (!rstN)
    noSolution |-> done);

  // R7: done holds without a start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R8: an active run never reports done
  a_r8_busy_not_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

endmodule

// File: rtl/relax_iter_ctrl.sv
module relax_iter_ctrl
  import relax_iter_pkg::*;
#(
  parameter int N_VERT    = 16,
  parameter int W_BITS    = 16,
  parameter int MEM_DEPTH = 64,
  localparam int IDX_W    = (N_VERT > 1) ? $clog2(N_VERT) : 1,
  localparam int WORD_W   = W_BITS + 2 * IDX_W,
  localparam int ADDR_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
  localparam int CNT_W    = $clog2(MEM_DEPTH + 1),
  localparam int ITER_W   = $clog2(N_VERT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              stopIn,
  output logic              edgeValid,
  output logic [WORD_W-1:0] edgeWord,
  output logic              flagReset,
  output logic              busy,
  output logic              done,
  output logic              noSolution,
  output logic [ITER_W-1:0] iterCount
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  relax_iter_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .stopIn     (stopIn),
    .status     (status),
    .strobe     (strobe),
    .edgeValid  (edgeValid),
    .flagReset  (flagReset),
    .busy       (busy),
    .done       (done),
    .noSolution (noSolution)
  );

  relax_iter_dp #(
    .N_VERT    (N_VERT),
    .W_BITS    (W_BITS),
    .MEM_DEPTH (MEM_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .cntWr     (cntWr),
    .cntIn     (cntIn),
    .strobe    (strobe),
    .feeding   (edgeValid),
    .status    (status),
    .edgeWord  (edgeWord),
    .iterCount (iterCount)
  );

endmodule

// File: tb/sim_relax_iter_ctrl.sv
module sim_relax_iter_ctrl;

  localparam int NV     = 4;
  localparam int WB     = 8;
  localparam int DEPTH  = 16;
  localparam int IDXW   = 2;
  localparam int WORDW  = WB + 2 * IDXW;
  localparam int ADDRW  = 4;
  localparam int CNTW   = 5;
  localparam int ITERW  = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             wrEn = 1'b0;
  logic [ADDRW-1:0] wrAddr = '0;
  logic [WORDW-1:0] wrData = '0;
  logic             cntWr = 1'b0;
  logic [CNTW-1:0]  cntIn = '0;
  logic             stopIn = 1'b0;
  logic             edgeValid, flagReset, busy, done, noSolution;
  logic [WORDW-1:0] edgeWord;
  logic [ITERW-1:0] iterCount;

  int checks = 0;
  int fails  = 0;
  logic [WORDW-1:0] expMem [DEPTH];
  int expE = 0;
  int stopIters = 0;
  int resetsSeen = 0;
  int wordIdx = 0;
  int wordsSeen = 0;
  bit monOn = 1'b0;

  always #2.5 clk = ~clk;

  relax_iter_ctrl #(.N_VERT(NV), .W_BITS(WB), .MEM_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cntWr(cntWr), .cntIn(cntIn), .stopIn(stopIn),
    .edgeValid(edgeValid), .edgeWord(edgeWord), .flagReset(flagReset),
    .busy(busy), .done(done), .noSolution(noSolution), .iterCount(iterCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expIters(input int c);
    return (c < NV) ? c + 1 : NV;
  endfunction

  // monitor: word stream and scripted change flag
  always @(negedge clk) begin
    if (monOn) begin
      if (flagReset) begin
        resetsSeen++;
        wordIdx = 0;
        check(!edgeValid, "R3 clear/valid overlap", 1, 0);
      end
      if (edgeValid) begin
        check(wordIdx < expE, "R2 word count", wordIdx, expE);
        if (wordIdx < expE)
          check(edgeWord == expMem[wordIdx], "R2 word value", int'(edgeWord), int'(expMem[wordIdx]));
        wordIdx++;
        wordsSeen++;
      end
      stopIn = (resetsSeen <= stopIters);
    end
  end

  task automatic loadGraph(input int e);
    for (int i = 0; i < e; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = ADDRW'(i); wrData = WORDW'($urandom);
      expMem[i] = wrData;
    end
    @(negedge clk);
    wrEn = 1'b0; cntWr = 1'b1; cntIn = CNTW'(e);
    expE = e;
    @(negedge clk);
    cntWr = 1'b0;
  endtask

  task automatic runCase(input int e, input int c, input bit midStart, input bit midWrite);
    int cyc;
    int k;
    loadGraph(e);
    stopIters = c; resetsSeen = 0; wordsSeen = 0; wordIdx = 0;
    monOn = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && noSolution == 1'b0, "R7 start clears result", int'(done), 0);
    cyc = 0;
    while (done == 1'b0 && cyc < 5000) begin
      cyc++;
      start = midStart && (cyc == 3);
      wrEn  = midWrite && (cyc == 4);
      cntWr = midWrite && (cyc == 4);
      wrAddr = '0; wrData = ~expMem[0]; cntIn = CNTW'(e + 1);
      @(negedge clk);
    end
    start = 1'b0; wrEn = 1'b0; cntWr = 1'b0;
    k = expIters(c);
    check(cyc < 5000, "R5 watchdog", cyc, k * (1 + e + 2 * NV));
    check(cyc == k * (1 + e + 2 * NV), (e == 0) ? "R10 run length" : "R4 run length",
          cyc, k * (1 + e + 2 * NV));
    check(resetsSeen == k, "R3 clear pulses", resetsSeen, k);
    check(wordsSeen == k * e, midWrite ? "R9 words per run" : "R2 words per run", wordsSeen, k * e);
    check(int'(iterCount) == k, midStart ? "R8 iterCount" : "R5 iterCount", int'(iterCount), k);
    if (c < NV) check(noSolution == 1'b0, "R5 noSolution", int'(noSolution), 0);
    else        check(noSolution == 1'b1, "R6 noSolution", int'(noSolution), 1);
    monOn = 1'b0;
    repeat (4) @(negedge clk);
    check(done == 1'b1 && int'(iterCount) == k && noSolution == (c >= NV),
          "R7 result held", int'(done), 1);
    if (midWrite) begin
      // stored word 0 and count untouched: replay with same expectations
      runCase2(e);
    end
  endtask

  task automatic runCase2(input int e);
    int cyc;
    stopIters = 0; resetsSeen = 0; wordsSeen = 0; wordIdx = 0;
    monOn = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (done == 1'b0 && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    check(wordsSeen == e, "R9 write ignored", wordsSeen, e);
    check(cyc == 1 + e + 2 * NV, "R9 count ignored", cyc, 1 + e + 2 * NV);
    monOn = 1'b0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(edgeValid == 0 && flagReset == 0 && done == 0 && noSolution == 0
          && busy == 0 && iterCount == 0, "R1 reset state", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && iterCount == 0, "R1 idle after reset", int'(busy), 0);
    runCase(16, 0, 1'b0, 1'b0);
    runCase(5, 2, 1'b1, 1'b0);
    runCase(1, 3, 1'b0, 1'b0);
    runCase(7, 4, 1'b0, 1'b1);
    runCase(0, 1, 1'b0, 1'b0);
    runCase(0, 6, 1'b1, 1'b0);
    runCase(9, 9, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      runCase(int'($urandom_range(0, DEPTH)), int'($urandom_range(0, 5)),
              1'(i % 2), 1'(i % 3 == 0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule